// File: doc/BRIEF.md
# Microcoded Single-Bus Accumulator CPU

This block is a small 8-bit accumulator processor built around a single shared 8-bit bus. The program counter, memory address register, instruction register, accumulator, operand register and output register all take their value from that bus, and each of the possible sources (program counter, accumulator, internal RAM read port and ALU) has its own drive enable. In any cycle at most one source drives the bus. A control store, indexed by an 11-bit address made of the step counter, the opcode and a three-bit comparison of the accumulator against the operand register, yields the strobes for every step. A 3-bit ALU select field is decoded one-hot, and only the chosen ALU lane is gated onto the bus.

Software is placed into the internal 256-byte RAM through a program port while `prog_mode` is high. While that input is high the sequencer makes no progress. When it is low the machine runs from reset. The first opcode is fetched from address 1, because the program counter is stepped before each fetch. A stop instruction freezes the machine, and `out_q` holds the final result.

Top module: `acc_cpu`

## Requirements
- R1: In every cycle at most one of the four bus sources (program counter, accumulator, RAM read, ALU) drives the bus.
- R2: Every instruction begins with a three-step fetch: program counter plus one, program counter to address register, RAM to instruction register. After reset the first opcode comes from address 1, and a stop placed at address 1 asserts `halted` on the 4th rising edge after the machine starts.
- R3: Opcode 0x1 (load immediate) copies the byte that follows the opcode into the accumulator. The full opcode map is: 0x0 no-op, 0x1 load immediate, 0x2 load operand register, 0x3 add, 0x4 subtract, 0x5 AND, 0x6 OR, 0x7 XOR, 0x8 stop, 0x9 invert, 0xA output, 0xB jump, 0xC jump-if-equal. Codes 0xD to 0xF are unused.
- R4: Opcodes 0x3 to 0x7 first load the following byte into the operand register. They then write accumulator op operand back to the accumulator, with arithmetic taken modulo 256.
- R5: Opcode 0x9 replaces the accumulator with its bitwise inverse.
- R6: Opcode 0xA copies the accumulator into `out_q`.
- R7: Opcode 0x8 sets `halted`. After that, `out_q` and all internal registers stay frozen until reset.
- R8: When an instruction completes, the instruction register and the step counter both return to zero, so the next instruction is fetched correctly.
- R9: An unused opcode (0xD to 0xF) resolves to a safe control word that ends the instruction and leaves the accumulator unchanged.
- R10: Opcode 0xB loads the following byte into the program counter. Execution resumes at that value plus one.
- R11: Opcode 0xC jumps in the same way as 0xB only when the accumulator equals the operand register. Otherwise it skips its operand byte.
- R12: While `prog_mode` is high, a write with `prog_we` stores `prog_data` at `prog_addr`, and the sequencer does not advance.
- R13: Asserting `rst_n` low clears `out_q` and `halted` immediately.
- R14: The ALU result reaches the bus through a one-hot decode of a 3-bit select, with only the selected lane gated on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prog_mode | input | 1 | High: RAM addressed by program port, sequencer frozen |
| prog_we | input | 1 | RAM write strobe in program mode |
| prog_addr | input | 8 | RAM address in program mode |
| prog_data | input | 8 | RAM write data in program mode |
| out_q | output | 8 | Output register |
| halted | output | 1 | High once a stop instruction has executed |

## Verification
The assertions check the following on every cycle:
- the bus has at most one driver;
- a fetch step always advances the program counter by one;
- a completed instruction leaves the step counter and instruction register at zero;
- a halted machine and a machine in program mode keep their registers still;
- a jump-if-equal only loads the program counter when the comparator reports equality.

The following can only be shown by the bench's programs:
- the arithmetic and logic results, including the wrap-around cases;
- the start at address 1 and the fetch length;
- the taken and untaken conditional branch;
- the harmlessness of an unused opcode.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

  localparam int DATA_W  = 8;
  localparam int OPC_W   = 4;
  localparam int STEP_W  = 4;
  localparam int CMP_W   = 3;
  localparam int CS_AW   = STEP_W + OPC_W + CMP_W;
  localparam int SEL_W   = 3;
  localparam int LANES   = 1 << SEL_W;
  localparam int STEP_MAX = 6;

  typedef logic [DATA_W-1:0] data_t;
  typedef logic [OPC_W-1:0]  opc_t;
  typedef logic [STEP_W-1:0] step_t;

  localparam opc_t OP_NOP = 4'h0;
  localparam opc_t OP_LDI = 4'h1;
  localparam opc_t OP_LDB = 4'h2;
  localparam opc_t OP_ADD = 4'h3;
  localparam opc_t OP_SUB = 4'h4;
  localparam opc_t OP_AND = 4'h5;
  localparam opc_t OP_OR  = 4'h6;
  localparam opc_t OP_XOR = 4'h7;
  localparam opc_t OP_HLT = 4'h8;
  localparam opc_t OP_NOT = 4'h9;
  localparam opc_t OP_OUT = 4'hA;
  localparam opc_t OP_JMP = 4'hB;
  localparam opc_t OP_JEQ = 4'hC;

  localparam logic [SEL_W-1:0] ALU_NONE = 3'd0;
  localparam logic [SEL_W-1:0] ALU_ADD  = 3'd1;
  localparam logic [SEL_W-1:0] ALU_SUB  = 3'd2;
  localparam logic [SEL_W-1:0] ALU_AND  = 3'd3;
  localparam logic [SEL_W-1:0] ALU_OR   = 3'd4;
  localparam logic [SEL_W-1:0] ALU_XOR  = 3'd5;
  localparam logic [SEL_W-1:0] ALU_NOT  = 3'd6;

  typedef struct packed {
    logic             pc_inc;
    logic             pc_out;
    logic             pc_in;
    logic             mar_in;
    logic             ram_out;
    logic             ir_in;
    logic             a_in;
    logic             a_out;
    logic             b_in;
    logic             out_in;
    logic [SEL_W-1:0] alu_sel;
    logic             done;
    logic             halt;
  } ctrl_t;

  // One ALU lane result; arithmetic wraps modulo 2**DATA_W.
  function automatic data_t alu_result(input logic [SEL_W-1:0] sel,
                                       input data_t a, input data_t b);
    case (sel)
      ALU_ADD: alu_result = a + b;
      ALU_SUB: alu_result = a - b;
      ALU_AND: alu_result = a & b;
      ALU_OR:  alu_result = a | b;
      ALU_XOR: alu_result = a ^ b;
      ALU_NOT: alu_result = ~a;
      default: alu_result = '0;
    endcase
  endfunction

  function automatic logic takes_operand(input opc_t op);
    takes_operand = (op == OP_LDI) || (op == OP_LDB) ||
                    (op >= OP_ADD && op <= OP_XOR) ||
                    (op == OP_JMP) || (op == OP_JEQ);
  endfunction

  function automatic logic [SEL_W-1:0] op_to_alu(input opc_t op);
    case (op)
      OP_ADD:  op_to_alu = ALU_ADD;
      OP_SUB:  op_to_alu = ALU_SUB;
      OP_AND:  op_to_alu = ALU_AND;
      OP_OR:   op_to_alu = ALU_OR;
      OP_XOR:  op_to_alu = ALU_XOR;
      default: op_to_alu = ALU_NONE;
    endcase
  endfunction

  // Control store: address = {cmp[2:0] (gt,eq,lt), opcode, step}.
  // Any entry that defines no strobe yields the safe word (done only).
  function automatic ctrl_t ctrl_lookup(input logic [CS_AW-1:0] addr);
    ctrl_t w;
    step_t st;
    opc_t  op;
    logic  eq;
    st = addr[STEP_W-1:0];
    op = addr[STEP_W+OPC_W-1:STEP_W];
    eq = addr[STEP_W+OPC_W+1];
    w  = '0;
    if (st == 4'd0) begin
      w.pc_inc = 1'b1;
    end else if (st == 4'd1) begin
      w.pc_out = 1'b1; w.mar_in = 1'b1;
    end else if (st == 4'd2) begin
      w.ram_out = 1'b1; w.ir_in = 1'b1;
    end else if (takes_operand(op) && st == 4'd3) begin
      w.pc_inc = 1'b1;
    end else if (takes_operand(op) && st == 4'd4) begin
      w.pc_out = 1'b1; w.mar_in = 1'b1;
    end else begin
      case (op)
        OP_LDI: if (st == 4'd5) begin
          w.ram_out = 1'b1; w.a_in = 1'b1; w.done = 1'b1;
        end
        OP_LDB: if (st == 4'd5) begin
          w.ram_out = 1'b1; w.b_in = 1'b1; w.done = 1'b1;
        end
        OP_ADD, OP_SUB, OP_AND, OP_OR, OP_XOR: begin
          if (st == 4'd5) begin
            w.ram_out = 1'b1; w.b_in = 1'b1;
          end else if (st == 4'd6) begin
            w.alu_sel = op_to_alu(op); w.a_in = 1'b1; w.done = 1'b1;
          end
        end
        OP_HLT: if (st == 4'd3) w.halt = 1'b1;
        OP_NOT: if (st == 4'd3) begin
          w.alu_sel = ALU_NOT; w.a_in = 1'b1; w.done = 1'b1;
        end
        OP_OUT: if (st == 4'd3) begin
          w.a_out = 1'b1; w.out_in = 1'b1; w.done = 1'b1;
        end
        OP_JMP: if (st == 4'd5) begin
          w.ram_out = 1'b1; w.pc_in = 1'b1; w.done = 1'b1;
        end
        OP_JEQ: if (st == 4'd5) begin
          if (eq) begin
            w.ram_out = 1'b1; w.pc_in = 1'b1;
          end
          w.done = 1'b1;
        end
        default: ;
      endcase
    end
    if (w == '0) w.done = 1'b1;
    return w;
  endfunction

endpackage

// File: rtl/acc_cpu_ram.sv
module acc_cpu_ram
  import acc_cpu_pkg::*;
#(
  parameter int ADDR_W = DATA_W
) (
  input  logic              clk,
  input  logic              prog_mode,
  input  logic              prog_we,
  input  logic [ADDR_W-1:0] prog_addr,
  input  data_t             prog_data,
  input  logic [ADDR_W-1:0] mar,
  output data_t             rd_data
);
  localparam int DEPTH = 1 << ADDR_W;

  data_t             mem [DEPTH];
  logic [ADDR_W-1:0] addr_sel;

  // Address multiplexer: program port in program mode, MAR when running.
  assign addr_sel = prog_mode ? prog_addr : mar;
  assign rd_data  = mem[addr_sel];

  always_ff @(posedge clk) begin
    if (prog_mode && prog_we) mem[addr_sel] <= prog_data;
  end
endmodule

// File: rtl/acc_cpu_alu.sv
module acc_cpu_alu
  import acc_cpu_pkg::*;
(
  input  logic [SEL_W-1:0] sel,
  input  data_t            a,
  input  data_t            b,
  output data_t            bus_drv,
  output logic             drive,
  output logic [CMP_W-1:0] cmp
);
  logic [LANES-1:0] lane_en;
  data_t            lane [LANES];

  // One-hot decode of the result select; lane 0 means "no ALU drive".
  assign lane_en = LANES'(1) << sel;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    if (k == 0) begin : g_idle
      assign lane[k] = '0;
    end else begin : g_op
      assign lane[k] = lane_en[k] ? alu_result(SEL_W'(k), a, b) : '0;
    end
  end

  always_comb begin
    bus_drv = '0;
    for (int k = 0; k < LANES; k++) bus_drv = bus_drv | lane[k];
  end

  assign drive = |lane_en[LANES-1:1];
  assign cmp   = {a > b, a == b, a < b};
endmodule

// File: rtl/acc_cpu_ctrl.sv
module acc_cpu_ctrl
  import acc_cpu_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             prog_mode,
  input  opc_t             ir,
  input  logic [CMP_W-1:0] cmp,
  output ctrl_t            cw,
  output step_t            step,
  output logic             run_en,
  output logic             halted
);
  logic [CS_AW-1:0] cs_addr;
  ctrl_t            cw_raw;

  assign cs_addr = {cmp, ir, step};
  assign cw_raw  = ctrl_lookup(cs_addr);
  assign run_en  = !prog_mode && !halted;
  assign cw      = run_en ? cw_raw : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step   <= '0;
      halted <= 1'b0;
    end else if (run_en) begin
      if (cw_raw.halt)      halted <= 1'b1;
      else if (cw_raw.done) step   <= '0;
      else                  step   <= step + 1'b1;
    end
  end

  // R8: the step counter never runs past the longest instruction
  a_r8_step_bound: assert property (@(posedge clk) disable iff (!rst_n)
    step <= step_t'(STEP_MAX));

  // R11: a conditional jump only loads the PC when the comparator says equal
  a_r11_jeq_needs_eq: assert property (@(posedge clk) disable iff (!rst_n)
    (cw.pc_in && ir == OP_JEQ) |-> cmp[1]);
endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
  import acc_cpu_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        prog_mode,
  input  logic        prog_we,
  input  logic [7:0]  prog_addr,
  input  logic [7:0]  prog_data,
  output logic [7:0]  out_q,
  output logic        halted
);
  data_t            pc_q, mar_q, a_q, b_q, bus, ram_rd, alu_bus;
  opc_t             ir_q;
  ctrl_t            cw;
  step_t            step;
  logic             run_en, alu_drive;
  logic [CMP_W-1:0] cmp;
  logic [3:0]       drivers;

  acc_cpu_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .prog_mode(prog_mode), .ir(ir_q), .cmp(cmp),
    .cw(cw), .step(step), .run_en(run_en), .halted(halted)
  );

  acc_cpu_alu u_alu (
    .sel(cw.alu_sel), .a(a_q), .b(b_q),
    .bus_drv(alu_bus), .drive(alu_drive), .cmp(cmp)
  );

  acc_cpu_ram u_ram (
    .clk(clk), .prog_mode(prog_mode), .prog_we(prog_we),
    .prog_addr(prog_addr), .prog_data(prog_data),
    .mar(mar_q), .rd_data(ram_rd)
  );

  // Shared bus: each source gated by its own enable, then merged.
  assign drivers = {cw.pc_out, cw.a_out, cw.ram_out, alu_drive};
  assign bus = (cw.pc_out  ? pc_q   : '0) |
               (cw.a_out   ? a_q    : '0) |
               (cw.ram_out ? ram_rd : '0) |
               alu_bus;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q  <= '0;
      mar_q <= '0;
      ir_q  <= '0;
      a_q   <= '0;
      b_q   <= '0;
      out_q <= '0;
    end else begin
      if (cw.pc_in)       pc_q <= bus;
      else if (cw.pc_inc) pc_q <= pc_q + 1'b1;
      if (cw.mar_in) mar_q <= bus;
      if (cw.done)       ir_q <= '0;
      else if (cw.ir_in) ir_q <= bus[OPC_W-1:0];
      if (cw.a_in)   a_q   <= bus;
      if (cw.b_in)   b_q   <= bus;
      if (cw.out_in) out_q <= bus;
    end
  end

  // R1: never more than one bus driver
  a_r1_one_driver: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(drivers));

  // R2: the first fetch step moves the PC up by one and enters step 1
  a_r2_fetch_step: assert property (@(posedge clk) disable iff (!rst_n)
    (step == '0 && run_en) |=> (step == step_t'(1) && pc_q == $past(pc_q) + 8'd1));

  // R8: completing an instruction leaves IR and step at zero
  a_r8_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (cw.done && !cw.halt) |=> (step == '0 && ir_q == '0));

  // R7: a halted machine stays halted with frozen state
  a_r7_halt_hold: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> (halted && $stable(pc_q) && $stable(a_q) && $stable(out_q)));

  // R12: program mode freezes the sequencer's registers
  a_r12_prog_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    prog_mode |=> ($stable(pc_q) && $stable(a_q) && $stable(ir_q) && $stable(step)));
endmodule

// File: tb/acc_cpu_bench.sv
`timescale 1ns/1ps
module acc_cpu_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       prog_mode = 1'b1;
  logic       prog_we = 1'b0;
  logic [7:0] prog_addr = '0;
  logic [7:0] prog_data = '0;
  logic [7:0] out_q;
  logic       halted;

  int checks = 0;
  int fails  = 0;
  logic [7:0] img [16];

  always #2.5 clk = ~clk;

  acc_cpu u_acc_cpu (
    .clk(clk), .rst_n(rst_n), .prog_mode(prog_mode), .prog_we(prog_we),
    .prog_addr(prog_addr), .prog_data(prog_data),
    .out_q(out_q), .halted(halted)
  );

  // op[19:16], a[15:8], b[7:0]
  localparam logic [19:0] VEC [9] = '{
    {4'h1, 8'h5A, 8'h00},
    {4'h3, 8'd45, 8'd34},
    {4'h3, 8'hFF, 8'h01},
    {4'h4, 8'h10, 8'h03},
    {4'h4, 8'h00, 8'h01},
    {4'h5, 8'hF0, 8'h3C},
    {4'h6, 8'h0F, 8'h30},
    {4'h7, 8'hAA, 8'hFF},
    {4'h9, 8'h45, 8'h00}
  };

  function automatic logic [7:0] model(input logic [3:0] op,
                                       input logic [7:0] a, input logic [7:0] b);
    logic [8:0] wide;
    case (op)
      4'h1: model = a;
      4'h3: begin wide = {1'b0, a} + {1'b0, b}; model = wide[7:0]; end
      4'h4: begin wide = {1'b0, a} + {1'b0, ~b} + 9'd1; model = wide[7:0]; end
      4'h5: model = a & b;
      4'h6: model = a | b;
      4'h7: model = (a | b) & ~(a & b);
      4'h9: model = 8'hFF - a;
      default: model = 8'h00;
    endcase
  endfunction

  function automatic string req_of(input logic [3:0] op);
    case (op)
      4'h1:    req_of = "R3 R6";
      4'h9:    req_of = "R5 R6 R14";
      default: req_of = "R4 R14";
    endcase
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic fill_halt();
    for (int i = 0; i < 16; i++) img[i] = 8'h08;
  endtask

  // Loads img under reset, holds program mode 'hold' extra cycles, runs.
  task automatic run_image(input int hold, output int cyc);
    @(negedge clk);
    rst_n = 1'b0;
    prog_mode = 1'b1;
    for (int i = 0; i < 16; i++) begin
      prog_addr = 8'(i);
      prog_data = img[i];
      prog_we = 1'b1;
      @(negedge clk);
    end
    prog_we = 1'b0;
    rst_n = 1'b1;
    repeat (hold) @(negedge clk);
    prog_mode = 1'b0;
    cyc = 0;
    while (!halted && cyc < 400) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin : main
    int cyc;
    // R13: reset state
    #1;
    chk("R13 out after reset", out_q, 8'h00);
    chk("R13 halted after reset", {7'd0, halted}, 8'h00);

    // R2 / R12: start at address 1, fetch length, program-mode freeze
    fill_halt();
    img[0] = 8'h01;
    run_image(10, cyc);
    chk("R2 R12 cycles to stop at address 1", 8'(cyc), 8'd4);
    chk("R2 out untouched", out_q, 8'h00);

    // Vector table: R3 R4 R5 R6 R14
    foreach (VEC[v]) begin
      logic [3:0] op;
      logic [7:0] a, b;
      op = VEC[v][19:16]; a = VEC[v][15:8]; b = VEC[v][7:0];
      fill_halt();
      img[1] = 8'h01; img[2] = a;
      if (op == 4'h1) begin
        img[3] = 8'h0A;
      end else if (op == 4'h9) begin
        img[3] = 8'h09; img[4] = 8'h0A;
      end else begin
        img[3] = {4'h0, op}; img[4] = b; img[5] = 8'h0A;
      end
      run_image(0, cyc);
      chk(req_of(op), out_q, model(op, a, b));
    end

    // Worked program: LDI 45, NOT, ADD 34, OUT, stop -> R1 R8
    fill_halt();
    img[1] = 8'h01; img[2] = 8'd45; img[3] = 8'h09;
    img[4] = 8'h03; img[5] = 8'd34; img[6] = 8'h0A;
    run_image(0, cyc);
    chk("R1 R8 chained program", out_q, 8'(model(4'h3, model(4'h9, 8'd45, 8'd0), 8'd34)));
    chk("R7 halted set", {7'd0, halted}, 8'h01);
    repeat (30) @(negedge clk);
    chk("R7 out frozen after stop", out_q, 8'd244);
    chk("R7 still halted", {7'd0, halted}, 8'h01);
    rst_n = 1'b0;
    #1;
    chk("R13 reset clears out", out_q, 8'h00);
    chk("R13 reset clears halted", {7'd0, halted}, 8'h00);

    // R9: unused opcode leaves accumulator alone
    fill_halt();
    img[1] = 8'h01; img[2] = 8'h22; img[3] = 8'h0D; img[4] = 8'h0A;
    run_image(0, cyc);
    chk("R9 unused opcode 0xD", out_q, 8'h22);
    fill_halt();
    img[1] = 8'h01; img[2] = 8'h3C; img[3] = 8'h0F; img[4] = 8'h0A;
    run_image(0, cyc);
    chk("R9 unused opcode 0xF", out_q, 8'h3C);

    // R10: jump to 6, resume at 7
    fill_halt();
    img[1] = 8'h01; img[2] = 8'h11; img[3] = 8'h0B; img[4] = 8'h06;
    img[7] = 8'h0A;
    run_image(0, cyc);
    chk("R10 jump resumes at target+1", out_q, 8'h11);

    // R11: conditional jump taken and not taken
    for (int t = 0; t < 2; t++) begin
      fill_halt();
      img[1] = 8'h01; img[2] = 8'h07; img[3] = 8'h02;
      img[4] = (t == 0) ? 8'h07 : 8'h08;
      img[5] = 8'h0C; img[6] = 8'h09; img[7] = 8'h01; img[8] = 8'h55;
      img[9] = 8'h0A; img[10] = 8'h0A;
      run_image(0, cyc);
      chk(t == 0 ? "R11 equal takes jump" : "R11 unequal falls through",
          out_q, t == 0 ? 8'h07 : 8'h55);
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule